// File: doc/BRIEF.md
# SPI-mode SD card command engine

This block runs one SD/MMC command exchange in SPI mode. It owns the SPI bit shifter, the byte sequencing of a command, the polling for the one-byte R1 answer and the classification of the result. A host pulses `cmd_start` with an opcode, a 32-bit argument and a response kind. The engine then shifts out the seven-byte frame and clocks out all-ones bytes until the card answers. It can collect one or four extra answer bytes. It finishes with a one-cycle `cmd_done` pulse and a status code.

A separate request, `pwrup_req`, sends the power-up preamble. During the preamble chip select is held high while all-ones bytes are clocked out. Chip select is then driven low and stays low for later commands. The SPI clock is the system clock divided by `2*CLK_DIV`. Its default of 63 gives about 400 kHz from 50 MHz.

Only a single data line is used. The control pins are plain pulses and levels with no back-pressure: a request that arrives while `busy` is high is dropped. The host must wait for `cmd_done` before it issues the next one. Result outputs hold their values until the next command is accepted.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: Out of reset `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 1, and `busy` and `cmd_done` are 0.
- R2: A `pwrup_req` pulse while idle clocks out `INIT_BYTES` (default 10) bytes of 0xFF with `spi_cs_n` held at 1 throughout. It then drives `spi_cs_n` to 0 and ends with `cmd_done` and status 0.
- R3: The SPI link uses mode 0. `spi_sclk` idles low, MISO is sampled on the rising edge, and MOSI changes only while `spi_sclk` is low. Bytes are sent MSB first, and MOSI idles at 1 between bytes.
- R4: An accepted command sends seven bytes in this order: 0xFF, then 0x40 OR the 6-bit opcode, then the four argument bytes from bits 31:24 down to bits 7:0, then a check byte.
- R5: The check byte is 0x95 for opcode 0, 0x87 for opcode 8 and 0x00 for every other opcode.
- R6: After the frame, the engine polls by sending 0xFF bytes. The first and second polled bytes are never taken as a response. The first byte from the third poll onward that has bit 7 clear is the R1 value, and `rsp16[7:0]` reports it.
- R7: If `TIMEOUT_POLLS` polled bytes pass without an accepted R1, the command ends with status 1 (timeout). No further bytes are sent, and `rsp16` and `rsp32` are 0.
- R8: Response kind 1 reads one extra byte after R1 into `rsp16[15:8]`. Kinds 0 and 3 read no extra byte.
- R9: Response kind 2 reads four extra bytes after R1 into `rsp32`, the first received in bits 31:24. `rsp16[15:8]` is then 0.
- R10: With an R1 accepted, the status is 0 (ok) when R1 is 0x00 or 0x01 and 2 (response error) otherwise. The extra bytes of R8 and R9 are read in either case.
- R11: `cmd_done` is a single-cycle pulse and `busy` is low in that cycle. `pwrup_req` wins over `cmd_start` when both arrive together. Both are ignored while `busy` is high, and an ignored request sends no bytes and produces no `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrup_req | input | 1 | Pulse: send the power-up preamble |
| cmd_start | input | 1 | Pulse: launch a command |
| cmd_opcode | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 R1 only, 1 R1 plus one byte, 2 R1 plus four bytes, 3 as 0 |
| busy | output | 1 | Preamble or command in progress |
| cmd_done | output | 1 | One-cycle end pulse |
| cmd_status | output | 2 | 0 ok, 1 timeout, 2 response error |
| rsp16 | output | 16 | {extra byte, R1} |
| rsp32 | output | 32 | Four extra response bytes |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Active-low card select |

## Verification
The embedded assertions check, on every cycle, the invariants that involve no scenario. These cover the MOSI hold while the clock is high, the clock idling low, the single-cycle end pulse with `busy` low, chip select held high during the preamble, the legal status codes, and a timeout only after the full poll budget. What the bench alone can show is content and order. That covers the frame bytes and check bytes per opcode, the skipping of early polled bytes, which polled byte becomes R1, and how the extra bytes land in `rsp16` and `rsp32`. The bench also confirms that a request made while busy leaves the wire silent. It exercises these through a byte-level card model fed with random and directed reply scripts.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [1:0] {
    CMD_OK      = 2'd0,
    CMD_TIMEOUT = 2'd1,
    CMD_RSP_ERR = 2'd2
  } cmd_status_e;

  typedef enum logic [1:0] {
    RK_SHORT  = 2'd0,
    RK_WIDE16 = 2'd1,
    RK_WIDE32 = 2'd2,
    RK_RSVD   = 2'd3
  } rsp_kind_e;

  localparam int FRAME_BYTES = 7;
  localparam int WIDE32_BYTES = 4;

  // fixed check byte: only the two opcodes that must carry a valid one
  function automatic logic [7:0] check_byte(input logic [5:0] op);
    case (op)
      6'd0:    return 8'h95;
      6'd8:    return 8'h87;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(input logic [2:0] idx,
                                            input logic [5:0] op,
                                            input logic [31:0] arg);
    case (idx)
      3'd0:    return 8'hFF;
      3'd1:    return {2'b01, op};
      3'd2:    return arg[31:24];
      3'd3:    return arg[23:16];
      3'd4:    return arg[15:8];
      3'd5:    return arg[7:0];
      3'd6:    return check_byte(op);
      default: return 8'hFF;
    endcase
  endfunction

  function automatic cmd_status_e classify(input logic [7:0] r1);
    return (r1 == 8'h00 || r1 == 8'h01) ? CMD_OK : CMD_RSP_ERR;
  endfunction

endpackage

// File: rtl/sdspi_byte_shifter.sv
module sdspi_byte_shifter #(
  parameter int CLK_DIV = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active;
  logic          sclk_q;
  logic [2:0]    bit_idx;
  logic [DW-1:0] div_cnt;
  logic [7:0]    tx_sr;
  logic [7:0]    rx_sr;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      bit_idx <= '0;
      div_cnt <= '0;
      tx_sr   <= 8'hFF;
      rx_sr   <= 8'h00;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          tx_sr   <= tx_byte;
          div_cnt <= '0;
          bit_idx <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sr  <= {rx_sr[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            tx_sr   <= {tx_sr[6:0], 1'b1};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = active ? tx_sr[7] : 1'b1;
  assign done    = done_q;
  assign rx_byte = rx_sr;

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);
  // R3
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);

endmodule

// File: rtl/sdspi_cmd_seq.sv
module sdspi_cmd_seq
  import sdspi_pkg::*;
#(
  parameter int INIT_BYTES    = 10,
  parameter int TIMEOUT_POLLS = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwrup_req,
  input  logic        cmd_start,
  input  logic [5:0]  cmd_opcode,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_kind,
  output logic        byte_go,
  output logic [7:0]  byte_tx,
  input  logic        byte_done,
  input  logic [7:0]  byte_rx,
  output logic        cs_n,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status,
  output logic [15:0] rsp16,
  output logic [31:0] rsp32
);
  localparam int IDX_MAX = (INIT_BYTES > FRAME_BYTES) ? INIT_BYTES : FRAME_BYTES;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam int PW      = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [IDX_W-1:0] INIT_LAST  = IDX_W'(INIT_BYTES - 1);
  localparam logic [IDX_W-1:0] FRAME_LAST = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] W32_LAST   = IDX_W'(WIDE32_BYTES - 1);
  localparam logic [PW-1:0]    POLL_LAST  = PW'(TIMEOUT_POLLS - 1);
  localparam logic [PW-1:0]    SKIP_POLLS = PW'(2);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_FRAME, S_POLL, S_EXTRA} seq_state_e;

  seq_state_e      state;
  logic            wait_q;
  logic [IDX_W-1:0] idx;
  logic [PW-1:0]   poll_cnt;
  logic [5:0]      op_q;
  logic [31:0]     arg_q;
  rsp_kind_e       kind_q;
  logic [7:0]      r1_q;
  cmd_status_e     status_q;

  assign byte_go = (state != S_IDLE) && !wait_q;
  assign busy    = (state != S_IDLE);
  assign status  = status_q;

  always_comb begin
    case (state)
      S_FRAME: byte_tx = frame_byte(idx[2:0], op_q, arg_q);
      default: byte_tx = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wait_q   <= 1'b0;
      idx      <= '0;
      poll_cnt <= '0;
      op_q     <= '0;
      arg_q    <= '0;
      kind_q   <= RK_SHORT;
      r1_q     <= '0;
      status_q <= CMD_OK;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      rsp16    <= '0;
      rsp32    <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        wait_q <= 1'b0;
        idx    <= '0;
        if (pwrup_req) begin
          state <= S_PRE;
          cs_n  <= 1'b1;
        end else if (cmd_start) begin
          state    <= S_FRAME;
          op_q     <= cmd_opcode;
          arg_q    <= cmd_arg;
          kind_q   <= rsp_kind_e'(rsp_kind);
          poll_cnt <= '0;
          rsp16    <= '0;
          rsp32    <= '0;
        end
      end else begin
        if (byte_go) wait_q <= 1'b1;
        if (byte_done) begin
          wait_q <= 1'b0;
          case (state)
            S_PRE: begin
              if (idx == INIT_LAST) begin
                state    <= S_IDLE;
                cs_n     <= 1'b0;
                done     <= 1'b1;
                status_q <= CMD_OK;
              end else idx <= idx + IDX_W'(1);
            end
            S_FRAME: begin
              if (idx == FRAME_LAST) begin
                state <= S_POLL;
                idx   <= '0;
              end else idx <= idx + IDX_W'(1);
            end
            S_POLL: begin
              if (!byte_rx[7] && poll_cnt >= SKIP_POLLS) begin
                r1_q  <= byte_rx;
                rsp16 <= {8'h00, byte_rx};
                if (kind_q == RK_WIDE16 || kind_q == RK_WIDE32) begin
                  state <= S_EXTRA;
                  idx   <= '0;
                end else begin
                  state    <= S_IDLE;
                  done     <= 1'b1;
                  status_q <= classify(byte_rx);
                end
              end else if (poll_cnt == POLL_LAST) begin
                state    <= S_IDLE;
                done     <= 1'b1;
                status_q <= CMD_TIMEOUT;
              end else begin
                poll_cnt <= poll_cnt + PW'(1);
              end
            end
            S_EXTRA: begin
              if (kind_q == RK_WIDE16) begin
                rsp16[15:8] <= byte_rx;
                state       <= S_IDLE;
                done        <= 1'b1;
                status_q    <= classify(r1_q);
              end else begin
                rsp32 <= {rsp32[23:0], byte_rx};
                if (idx == W32_LAST) begin
                  state    <= S_IDLE;
                  done     <= 1'b1;
                  status_q <= classify(r1_q);
                end else idx <= idx + IDX_W'(1);
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  pre_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |-> cs_n);
  // R10
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'd3));
  // R7
  timeout_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == CMD_TIMEOUT) |-> (poll_cnt == POLL_LAST));
  // R3
  done_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> wait_q);

endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine #(
  parameter int CLK_DIV       = 63,
  parameter int INIT_BYTES    = 10,
  parameter int TIMEOUT_POLLS = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwrup_req,
  input  logic        cmd_start,
  input  logic [5:0]  cmd_opcode,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_kind,
  output logic        busy,
  output logic        cmd_done,
  output logic [1:0]  cmd_status,
  output logic [15:0] rsp16,
  output logic [31:0] rsp32,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic       byte_go;
  logic [7:0] byte_tx;
  logic       byte_done;
  logic [7:0] byte_rx;

  sdspi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (byte_go),
    .tx_byte (byte_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (byte_done),
    .rx_byte (byte_rx)
  );

  sdspi_cmd_seq #(
    .INIT_BYTES    (INIT_BYTES),
    .TIMEOUT_POLLS (TIMEOUT_POLLS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrup_req  (pwrup_req),
    .cmd_start  (cmd_start),
    .cmd_opcode (cmd_opcode),
    .cmd_arg    (cmd_arg),
    .rsp_kind   (rsp_kind),
    .byte_go    (byte_go),
    .byte_tx    (byte_tx),
    .byte_done  (byte_done),
    .byte_rx    (byte_rx),
    .cs_n       (spi_cs_n),
    .busy       (busy),
    .done       (cmd_done),
    .status     (cmd_status),
    .rsp16      (rsp16),
    .rsp32      (rsp32)
  );

  // R3
  sclk_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

endmodule

// File: tb/tb_sdspi_cmd_engine.sv
module tb_sdspi_cmd_engine;
  localparam int DIV = 2;
  localparam int TMO = 24;
  localparam int NINIT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrup_req = 1'b0, cmd_start = 1'b0;
  logic [5:0] cmd_opcode = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0] rsp_kind = '0;
  logic busy, cmd_done, spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b1;
  logic [1:0] cmd_status;
  logic [15:0] rsp16;
  logic [31:0] rsp32;

  always #10 clk = ~clk;

  sdspi_cmd_engine #(.CLK_DIV(DIV), .INIT_BYTES(NINIT), .TIMEOUT_POLLS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .pwrup_req(pwrup_req), .cmd_start(cmd_start),
    .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
    .busy(busy), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .rsp16(rsp16), .rsp32(rsp32), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int checks = 0, failures = 0;
  logic [7:0] script [0:63];
  logic [7:0] cap [0:127];
  int byte_no = 0, bitc = 0;
  logic [7:0] sh = 8'h00, cur = 8'hFF;

  function automatic logic [7:0] reply(input int n);
    if (n < 7 || n - 7 > 63) return 8'hFF;
    return script[n-7];
  endfunction

  // card model: samples MOSI on rising SCLK, changes MISO on falling SCLK
  always @(posedge spi_sclk) begin
    logic [7:0] nb;
    nb = {sh[6:0], spi_mosi};
    sh = nb;
    bitc = bitc + 1;
    if (bitc == 8) begin
      if (byte_no < 128) cap[byte_no] = nb;
      byte_no = byte_no + 1;
      bitc = 0;
    end
  end
  always @(negedge spi_sclk) begin
    if (bitc == 0) begin
      cur = reply(byte_no);
      spi_miso = cur[7];
    end else spi_miso = cur[7-bitc];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_check(input logic [5:0] op);
    if (op == 6'd0) return 8'h95;
    if (op == 6'd8) return 8'h87;
    return 8'h00;
  endfunction

  // reference model of the result from the reply script
  int e_bytes; logic [1:0] e_st; logic [15:0] e16; logic [31:0] e32;
  task automatic predict(input logic [1:0] kind);
    int at;
    at = -1;
    for (int p = 2; p < TMO; p++) if (at < 0 && !script[p][7]) at = p;
    e16 = '0; e32 = '0;
    if (at < 0) begin
      e_st = 2'd1; e_bytes = 7 + TMO;
    end else begin
      logic [7:0] r1;
      r1 = script[at];
      e_st = (r1 == 8'h00 || r1 == 8'h01) ? 2'd0 : 2'd2;
      e16 = {8'h00, r1};
      e_bytes = 7 + at + 1;
      if (kind == 2'd1) begin
        e16[15:8] = script[at+1]; e_bytes += 1;
      end else if (kind == 2'd2) begin
        e32 = {script[at+1], script[at+2], script[at+3], script[at+4]};
        e_bytes += 4;
      end
    end
  endtask

  task automatic wait_done(output int dones, output bit seen);
    dones = 0; seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (cmd_done) begin dones++; seen = 1; end
    end
    if (!seen) begin
      failures++;
      $display("FAIL R11 watchdog: no done actual=0 expected=1");
    end
  endtask

  task automatic run_cmd(input logic [5:0] op, input logic [31:0] arg,
                         input logic [1:0] kind, input bit poke_busy);
    int dones; bit seen; int nb;
    predict(kind);
    byte_no = 0; bitc = 0; spi_miso = 1'b1;
    @(negedge clk);
    cmd_opcode = op; cmd_arg = arg; rsp_kind = kind; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (poke_busy) begin
      repeat (60) @(negedge clk);
      cmd_opcode = ~op; cmd_arg = ~arg; cmd_start = 1'b1; pwrup_req = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0; pwrup_req = 1'b0;
      cmd_opcode = op; cmd_arg = arg;
    end
    wait_done(dones, seen);
    chk("R4 lead byte", cap[0], 8'hFF);
    chk("R4 opcode byte", cap[1], {2'b01, op});
    chk("R4 arg bytes", {cap[2], cap[3], cap[4], cap[5]}, arg);
    chk("R5 check byte", cap[6], exp_check(op));
    chk("R6 R7 byte count", byte_no, e_bytes);
    begin
      bit allff = 1;
      for (int i = 7; i < e_bytes && i < 128; i++) if (cap[i] !== 8'hFF) allff = 0;
      chk("R6 poll bytes all ones", allff, 1);
    end
    chk("R10 R7 status", cmd_status, e_st);
    chk("R6 R8 rsp16", rsp16, e16);
    chk("R9 rsp32", rsp32, e32);
    chk("R11 busy low at done", busy, 1'b0);
    nb = byte_no;
    @(negedge clk);
    chk("R11 done single cycle", cmd_done, 1'b0);
    repeat (3 * 16 * DIV) @(negedge clk);
    if (poke_busy) begin
      chk("R11 ignored request: no bytes", byte_no, nb);
      chk("R11 ignored request: idle", busy, 1'b0);
      chk("R11 ignored preamble keeps cs low", spi_cs_n, 1'b0);
    end
  endtask

  task automatic fill_ff();
    for (int i = 0; i < 64; i++) script[i] = 8'hFF;
  endtask

  initial begin
    int dones; bit seen; bit cs_bad;
    void'($urandom(32'd20240611));
    fill_ff();
    repeat (3) @(negedge clk);
    chk("R1 cs_n reset", spi_cs_n, 1'b1);
    chk("R1 sclk reset", spi_sclk, 1'b0);
    chk("R1 mosi reset", spi_mosi, 1'b1);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 done reset", cmd_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 preamble
    byte_no = 0; bitc = 0;
    pwrup_req = 1'b1; @(negedge clk); pwrup_req = 1'b0;
    cs_bad = 0; seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (busy && !spi_cs_n) cs_bad = 1;
      if (cmd_done) seen = 1;
    end
    chk("R2 preamble done", seen, 1);
    if (!seen) failures++;
    chk("R2 cs high during preamble", cs_bad, 0);
    chk("R2 preamble byte count", byte_no, NINIT);
    begin
      bit allff = 1;
      for (int i = 0; i < NINIT; i++) if (cap[i] !== 8'hFF) allff = 0;
      chk("R2 preamble bytes all ones", allff, 1);
    end
    chk("R2 preamble status", cmd_status, 2'd0);
    @(negedge clk);
    chk("R2 cs low after preamble", spi_cs_n, 1'b0);

    // R6: early bit7-clear bytes skipped, R1=01 at poll 4; R5 opcode 0
    fill_ff(); script[0] = 8'h00; script[1] = 8'h01; script[3] = 8'h01;
    run_cmd(6'd0, 32'h0, 2'd0, 0);
    // R9 + R5 opcode 8
    fill_ff(); script[2] = 8'h01; script[3] = 8'h00; script[4] = 8'h00;
    script[5] = 8'h01; script[6] = 8'hAA;
    run_cmd(6'd8, 32'h0000_01AA, 2'd2, 0);
    // R8
    fill_ff(); script[2] = 8'h00; script[3] = 8'h5A;
    run_cmd(6'd13, 32'hDEAD_BEEF, 2'd1, 0);
    // R10 response error, extras still read (kind 1)
    fill_ff(); script[5] = 8'h05; script[6] = 8'hC3;
    run_cmd(6'd17, 32'h1234_5678, 2'd1, 0);
    // R7 timeout
    fill_ff();
    run_cmd(6'd55, 32'h0000_0001, 2'd2, 0);
    // R7 boundary: answer on the last allowed poll
    fill_ff(); script[TMO-1] = 8'h00;
    run_cmd(6'd24, 32'h0F0F_0F0F, 2'd0, 0);
    // R11 requests while busy are ignored
    fill_ff(); script[9] = 8'h00;
    run_cmd(6'd9, 32'hA5A5_5A5A, 2'd0, 1);

    // random scripts
    for (int n = 0; n < 30; n++) begin
      int at; logic [1:0] kind;
      at = $urandom % (TMO + 3);
      for (int p = 0; p < 64; p++) begin
        if (p < 2) script[p] = 8'($urandom);
        else if (p < at) script[p] = 8'($urandom) | 8'h80;
        else if (p == at) begin
          int sel;
          sel = $urandom % 4;
          script[p] = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : (8'($urandom) & 8'h7F);
        end else script[p] = 8'($urandom);
      end
      kind = 2'($urandom);
      run_cmd(6'($urandom), $urandom, kind, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule